// File: doc/BRIEF.md
# Systolic Longest-Match Search Array

This block finds, for one lookahead string, the longest prefix match against every starting position of a dictionary that is streamed in one symbol per cycle. A row of comparison elements each holds one lookahead symbol. The dictionary stream moves through the row one element per cycle. It enters at the element that holds the last lookahead symbol and moves toward the element that holds the first one. Because of this direction, all the equality flags that belong to one candidate start position are ready in the same cycle. They need no deskew registers.

A prefix encoder reduces the flag vector to a match length for each candidate. A result tracker keeps the longest length found and the earliest position where it occurred. A search begins with a start pulse that also samples the lookahead word. The dictionary symbols follow on consecutive cycles. When the last candidate has been scored, a one-cycle done strobe is raised and the result stays on the outputs.

Top module: `lz_match_array`

## Requirements
- R1: While reset is asserted and directly after it, `done`, `best_len` and `best_pos` are all zero.
- R2: Lookahead symbol k is taken from `la_in[k*SYM_W +: SYM_W]` in the cycle `start` is high. A candidate's length is the number of consecutive lookahead symbols, counted from symbol 0, that equal the dictionary symbols beginning at that candidate.
- R3: When several candidates reach the same best length, the smallest position is reported. A later candidate replaces the stored result only with a strictly greater length.
- R4: Candidate positions run from 0 to `N_DICT-LA_LEN`, where position p means dictionary symbol p (the p-th symbol after start) is aligned to lookahead symbol 0. Partial matches whose window would run past the last dictionary symbol are never candidates.
- R5: Dictionary symbol j must be on `sym_in` in the (j+1)-th cycle after the `start` cycle. `done` is high for exactly one cycle, `N_DICT+3` cycles after the `start` cycle, and is low at all other times.
- R6: From the `done` cycle until the next `start`, `best_len` and `best_pos` hold their values whatever `sym_in` does.
- R7: A `start` during a running search abandons it. Only the new search produces a `done`, and the result depends only on the new lookahead and stream.
- R8: If no candidate matches even its first symbol, the result is length 0 at position 0.
- R9: A candidate whose whole window equals the lookahead reports length `LA_LEN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a search and samples `la_in` |
| la_in | input | LA_LEN*SYM_W | Lookahead symbols, symbol k at bits k*SYM_W upward |
| sym_in | input | SYM_W | Dictionary symbol stream |
| best_pos | output | max(1,clog2(N_DICT-LA_LEN+1)) | Earliest position of the longest match |
| best_len | output | clog2(LA_LEN+1) | Longest match length |
| done | output | 1 | One-cycle strobe when the result is final |

## Verification
The bench uses the default build: 8-bit symbols, a 4-symbol lookahead and a 16-symbol dictionary, which gives 13 candidates for each search. This row is short enough that random streams drawn from a three-letter alphabet often produce full-length matches, ties between distant positions and partial matches cut off at the dictionary end. Each of these is compared against a brute-force search. The short dictionary also lets restarts, the done timing and the hold behaviour after done be checked many times within the run.

// File: rtl/lzsa_pkg.sv
package lzsa_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } lzsa_state_e;

  function automatic int width_of(input int count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction
endpackage

// File: rtl/lzsa_pe.sv
module lzsa_pe #(
  parameter int SYM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic             en,
  input  logic [SYM_W-1:0] la_d,
  input  logic [SYM_W-1:0] x_d,
  output logic [SYM_W-1:0] x_q,
  output logic             eq_q
);
  logic [SYM_W-1:0] la_q, la_nx, x_nx;
  logic             eq_nx;

  always_comb begin
    la_nx = ld ? la_d : la_q;
    x_nx  = en ? x_d : x_q;
    eq_nx = en ? (x_q == la_q) : eq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      la_q <= '0;
      x_q  <= '0;
      eq_q <= 1'b0;
    end else begin
      la_q <= la_nx;
      x_q  <= x_nx;
      eq_q <= eq_nx;
    end
  end
endmodule

// File: rtl/lzsa_len_enc.sv
module lzsa_len_enc #(
  parameter int LA_LEN = 4,
  parameter int LENW   = 3
) (
  input  logic [LA_LEN-1:0] eq,
  output logic [LENW-1:0]   len
);
  logic run;

  always_comb begin
    len = '0;
    run = 1'b1;
    for (int k = 0; k < LA_LEN; k++) begin
      if (run && eq[k]) len = len + LENW'(1);
      else              run = 1'b0;
    end
  end
endmodule

// File: rtl/lzsa_ctrl.sv
module lzsa_ctrl
  import lzsa_pkg::*;
#(
  parameter int LA_LEN = 4,
  parameter int N_DICT = 16,
  parameter int POSW   = 4,
  parameter int CNTW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            busy,
  output logic            cand_vld,
  output logic [POSW-1:0] cand_pos,
  output logic            done
);
  localparam logic [CNTW-1:0] FIRST_CAND = CNTW'(LA_LEN + 1);
  localparam logic [CNTW-1:0] LAST_CYC   = CNTW'(N_DICT + 1);

  lzsa_state_e     state_q, state_nx;
  logic [CNTW-1:0] cyc_q, cyc_nx;
  logic            done_nx;

  always_comb begin
    state_nx = state_q;
    cyc_nx   = cyc_q;
    done_nx  = 1'b0;
    if (start) begin
      state_nx = ST_RUN;
      cyc_nx   = '0;
    end else if (state_q == ST_RUN) begin
      cyc_nx = cyc_q + CNTW'(1);
      if (cyc_q == LAST_CYC) begin
        state_nx = ST_IDLE;
        done_nx  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cyc_q   <= '0;
      done    <= 1'b0;
    end else begin
      state_q <= state_nx;
      cyc_q   <= cyc_nx;
      done    <= done_nx;
    end
  end

  assign busy     = (state_q == ST_RUN);
  assign cand_vld = busy && !start && (cyc_q >= FIRST_CAND);
  assign cand_pos = POSW'(cyc_q - FIRST_CAND);

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_restart_no_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done);
endmodule

// File: rtl/lzsa_best_trk.sv
module lzsa_best_trk #(
  parameter int LENW = 3,
  parameter int POSW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            cand_vld,
  input  logic [LENW-1:0] cand_len,
  input  logic [POSW-1:0] cand_pos,
  output logic [LENW-1:0] best_len,
  output logic [POSW-1:0] best_pos
);
  logic [LENW-1:0] len_nx;
  logic [POSW-1:0] pos_nx;

  always_comb begin
    len_nx = best_len;
    pos_nx = best_pos;
    if (start) begin
      len_nx = '0;
      pos_nx = '0;
    end else if (cand_vld && (cand_len > best_len)) begin
      len_nx = cand_len;
      pos_nx = cand_pos;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_len <= '0;
      best_pos <= '0;
    end else begin
      best_len <= len_nx;
      best_pos <= pos_nx;
    end
  end

  p_keep_earliest_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && cand_vld && (cand_len <= best_len)) |=> ($stable(best_pos) && $stable(best_len)));
  p_take_greater_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && cand_vld && (cand_len > best_len)) |=>
      ((best_len == $past(cand_len)) && (best_pos == $past(cand_pos))));
  p_clear_on_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ((best_len == '0) && (best_pos == '0)));
endmodule

// File: rtl/lz_match_array.sv
module lz_match_array
  import lzsa_pkg::*;
#(
  parameter int SYM_W  = 8,
  parameter int LA_LEN = 4,
  parameter int N_DICT = 16,
  localparam int LENW  = $clog2(LA_LEN + 1),
  localparam int POSW  = width_of(N_DICT - LA_LEN + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [LA_LEN*SYM_W-1:0] la_in,
  input  logic [SYM_W-1:0]        sym_in,
  output logic [POSW-1:0]         best_pos,
  output logic [LENW-1:0]         best_len,
  output logic                    done
);
  localparam int CNTW = $clog2(N_DICT + 3);

  logic                  busy, cand_vld;
  logic [POSW-1:0]       cand_pos;
  logic [LENW-1:0]       cand_len;
  logic [LA_LEN-1:0]     eq;
  logic [SYM_W-1:0]      xs [LA_LEN];

  lzsa_ctrl #(
    .LA_LEN(LA_LEN), .N_DICT(N_DICT), .POSW(POSW), .CNTW(CNTW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .cand_vld(cand_vld), .cand_pos(cand_pos), .done(done)
  );

  // The stream enters at the last element and moves toward element 0,
  // so every flag of one candidate lands in the same cycle.
  for (genvar k = 0; k < LA_LEN; k++) begin : g_pe
    logic [SYM_W-1:0] x_in;
    if (k == LA_LEN - 1) begin : g_head
      assign x_in = sym_in;
    end else begin : g_link
      assign x_in = xs[k+1];
    end
    lzsa_pe #(.SYM_W(SYM_W)) u_pe (
      .clk(clk), .rst_n(rst_n), .ld(start), .en(busy),
      .la_d(la_in[k*SYM_W +: SYM_W]), .x_d(x_in),
      .x_q(xs[k]), .eq_q(eq[k])
    );
  end

  lzsa_len_enc #(.LA_LEN(LA_LEN), .LENW(LENW)) u_enc (
    .eq(eq), .len(cand_len)
  );

  lzsa_best_trk #(.LENW(LENW), .POSW(POSW)) u_trk (
    .clk(clk), .rst_n(rst_n), .start(start), .cand_vld(cand_vld),
    .cand_len(cand_len), .cand_pos(cand_pos),
    .best_len(best_len), .best_pos(best_pos)
  );

  p_len_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_vld && !eq[0]) |-> (cand_len == '0));
  p_len_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_vld && (&eq)) |-> (cand_len == LENW'(LA_LEN)));
  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(best_len) && $stable(best_pos)));
  p_pos_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cand_vld |-> (int'(cand_pos) <= N_DICT - LA_LEN));
endmodule

// File: tb/tb_lz_match_array.sv
`timescale 1ns/1ps
module tb_lz_match_array;
  localparam int W  = 8;
  localparam int LA = 4;
  localparam int N  = 16;
  localparam int LW = $clog2(LA + 1);
  localparam int PW = ((N - LA + 1) > 1) ? $clog2(N - LA + 1) : 1;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            start;
  logic [LA*W-1:0] la_in;
  logic [W-1:0]    sym_in;
  logic [PW-1:0]   best_pos;
  logic [LW-1:0]   best_len;
  logic            done;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [W-1:0] la   [LA];
  logic [W-1:0] dict [N];
  int exp_len, exp_pos;

  always #2.5 clk = ~clk;

  lz_match_array #(.SYM_W(W), .LA_LEN(LA), .N_DICT(N)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .la_in(la_in), .sym_in(sym_in),
    .best_pos(best_pos), .best_len(best_len), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model();
    exp_len = 0;
    exp_pos = 0;
    for (int p = 0; p <= N - LA; p++) begin
      int l = 0;
      while (l < LA && dict[p+l] == la[l]) l++;
      if (l > exp_len) begin
        exp_len = l;
        exp_pos = p;
      end
    end
  endtask

  task automatic issue_start();
    @(negedge clk);
    start = 1'b1;
    for (int k = 0; k < LA; k++) la_in[k*W +: W] = la[k];
    sym_in = W'($urandom);
  endtask

  // Streams the dictionary after a start and checks timing and result.
  task automatic stream_and_check(input string tag);
    int early = 0;
    model();
    for (int j = 0; j < N; j++) begin
      @(negedge clk);
      start = 1'b0;
      sym_in = dict[j];
      la_in = LA*W'($urandom);
      if (done) early++;
    end
    for (int c = 1; c <= 2; c++) begin
      @(negedge clk);
      sym_in = W'($urandom);
      if (done) early++;
    end
    chk(early == 0, {"R5 no early done ", tag}, early, 0);
    @(negedge clk);
    sym_in = W'($urandom);
    chk(done == 1'b1, {"R5 done on time ", tag}, int'(done), 1);
    chk(int'(best_len) == exp_len, {"R2 length ", tag}, int'(best_len), exp_len);
    chk(int'(best_pos) == exp_pos, {"R3 position ", tag}, int'(best_pos), exp_pos);
    @(negedge clk);
    sym_in = W'($urandom);
    chk(done == 1'b0, {"R5 done one cycle ", tag}, int'(done), 0);
  endtask

  task automatic run_search(input string tag);
    issue_start();
    stream_and_check(tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0;
    start = 1'b0;
    la_in = '0;
    sym_in = '0;
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1 done in reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0, "R1 done after reset", int'(done), 0);
    chk(best_len == '0, "R1 length after reset", int'(best_len), 0);
    chk(best_pos == '0, "R1 position after reset", int'(best_pos), 0);

    // R8: nothing matches
    for (int k = 0; k < LA; k++) la[k] = W'(8'h11 * (k + 1));
    for (int j = 0; j < N; j++) dict[j] = W'(8'h80 + j);
    run_search("R8 no match");

    // R9 and R4: full match at the last candidate
    for (int j = 0; j < N; j++) dict[j] = W'(8'h80 + j);
    for (int k = 0; k < LA; k++) dict[N-LA+k] = la[k];
    run_search("R9 full match at last position");

    // R3: two full matches, earlier wins
    for (int j = 0; j < N; j++) dict[j] = W'(8'h80 + j);
    for (int k = 0; k < LA; k++) begin
      dict[2+k] = la[k];
      dict[9+k] = la[k];
    end
    run_search("R3 tie");

    // R4: partial match running off the end is not a candidate
    for (int j = 0; j < N; j++) dict[j] = W'(8'h80 + j);
    dict[5] = la[0];
    dict[N-2] = la[0];
    dict[N-1] = la[1];
    run_search("R4 tail excluded");

    // R6: result holds after done while the stream keeps moving
    begin
      logic [LW-1:0] hl;
      logic [PW-1:0] hp;
      int moved = 0;
      hl = best_len;
      hp = best_pos;
      repeat (10) begin
        @(negedge clk);
        sym_in = W'($urandom);
        if (best_len != hl || best_pos != hp || done) moved++;
      end
      chk(moved == 0, "R6 hold after done", moved, 0);
    end

    // R7: restart in the middle of a search
    for (int k = 0; k < LA; k++) la[k] = W'(8'h40 + k);
    for (int j = 0; j < N; j++) dict[j] = la[j % LA];
    issue_start();
    for (int j = 0; j < 6; j++) begin
      @(negedge clk);
      start = 1'b0;
      sym_in = dict[j];
    end
    for (int k = 0; k < LA; k++) la[k] = W'(8'h20 + k);
    for (int j = 0; j < N; j++) dict[j] = W'(8'h90 + j);
    dict[7] = la[0];
    dict[8] = la[1];
    dict[9] = la[2];
    run_search("R7 restart");

    // Random and repetitive streams over a small alphabet
    for (int t = 0; t < 60; t++) begin
      for (int k = 0; k < LA; k++) la[k] = W'($urandom % 3);
      if (t % 4 == 0) begin
        for (int j = 0; j < N; j++) dict[j] = la[j % LA];
      end else if (t % 4 == 1) begin
        for (int j = 0; j < N; j++) dict[j] = W'(j % 2);
      end else begin
        for (int j = 0; j < N; j++) dict[j] = W'($urandom % 3);
      end
      run_search($sformatf("R2 random %0d", t));
      if (t % 7 == 0) repeat ($urandom % 4) @(negedge clk);
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule